// File: doc/BRIEF.md
# Floating-Point Control Word and Deferred Exception Unit

This block keeps the 16-bit control word of a floating-point unit and the six sticky exception flags of its status word. For each decoded floating-point instruction it decides whether a fault is reported. When no fault is reported, it commits the instruction's effect on that state. A load of a new control word never faults because of the flags it unmasks. Instead, a set flag whose mask bit becomes 0 arms a pending exception. That exception is reported only when the next waiting floating-point instruction arrives. No-wait instructions pass it by and leave it armed.

Before it commits, the block runs the access checks for the instruction in a fixed priority order: a locked encoding, then the coprocessor-unavailable bits, then operand alignment, then the math fault. A reported fault blocks every update. The datapath raises exception flags through `flag_set`. These flags are merged in when a waiting or no-wait operation completes.

The block is built around a two-state machine that tracks whether an exception is armed. In state `ST_QUIET`, no set flag is unmasked. In state `ST_ARMED`, at least one set flag is unmasked. The machine takes transition `ARM` from `ST_QUIET` to `ST_ARMED` when a committed load clears a mask bit over a set flag, or when a completed operation sets a flag that is unmasked. It takes transition `DISARM` from `ST_ARMED` to `ST_QUIET` when a clear-exceptions commits or a load masks every set flag. In all other cases the state holds. A math fault does not leave `ST_ARMED`, because the faulting instruction commits nothing.

Top module: `fpcw_unit`

## Requirements
- R1: After reset the control word is 16'h037F, all six exception flags are 0, and `fault_vld` is 0.
- R2: A committed load (`op_class` = 0) replaces all 16 bits of the control word with `ld_data`. The result is visible on `ctrl_word` one cycle after the operation cycle.
- R3: A load that leaves a set flag unmasked does not fault outside 64-bit mode. The next waiting operation (`op_class` = 2) then faults with code 4. Flag bit i (bits 0 to 5) is masked when control-word bit i is 1.
- R4: A no-wait operation (`op_class` = 3) never reports code 4, and it leaves an armed exception armed for the next waiting operation.
- R5: A committed clear-exceptions (`op_class` = 1) sets all flags to 0. A load that follows it then cannot arm an exception.
- R6: When `lock_pfx` is set on any valid operation, fault code 1 is reported, ahead of every other check.
- R7: When `cr0_em` or `cr0_ts` is set, fault code 2 is reported, ahead of the alignment and math checks.
- R8: When a load has `addr_misalign` and `ac_en` set, fault code 3 is reported in these cases: in virtual-8086 mode (`cpu_mode` = 2) at any `cpl`, and in protected mode (1) or 64-bit mode (3) only at `cpl` = 3. It is never reported in real mode (0), and never for other classes.
- R9: In 64-bit mode, a load that executes while an exception is armed reports code 4.
- R10: A reported fault leaves the control word and the flags unchanged.
- R11: A committed waiting or no-wait operation ORs `flag_set` into the flags.
- R12: `fault_vld` is a one-cycle pulse in the cycle after the faulting operation. `fault_code` is 0 whenever `fault_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_class | input | 2 | 0 load control word, 1 clear exceptions, 2 waiting op, 3 no-wait op |
| ld_data | input | 16 | Operand of a control-word load |
| flag_set | input | 6 | Exception flags raised by a completing op |
| lock_pfx | input | 1 | Instruction carries a lock prefix |
| cr0_em | input | 1 | Emulation bit of CR0 |
| cr0_ts | input | 1 | Task-switched bit of CR0 |
| ac_en | input | 1 | Alignment checking enabled |
| cpl | input | 2 | Current privilege level |
| cpu_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 64-bit |
| addr_misalign | input | 1 | Operand address is misaligned |
| ctrl_word | output | 16 | Current control word |
| stat_flags | output | 6 | Sticky exception flags |
| fault_vld | output | 1 | Fault reported for the previous op |
| fault_code | output | 3 | 0 none, 1 invalid opcode, 2 device not available, 3 alignment, 4 math |

## Verification
The deferred raise is tried with three patterns: a masked flag followed by a waiting op, an unmasked flag reached through a load followed by no-wait ops and then a waiting op, and a clear followed by a fully unmasking load. Together these separate a pending exception from one that is only masked, and from one that was cleared. The checks are combined pairwise to show their priority, for example a locked load with CR0 bits set and a misaligned address, or an alignment fault in 64-bit mode while an exception is armed. Each mode is also paired with each privilege level to separate the alignment rules. A random stream compared against a behavioural model covers interleavings that the directed cases miss.

// File: rtl/fpcw_pkg.sv
`timescale 1ns/1ps
package fpcw_pkg;
    typedef enum logic [1:0] {
        OP_LDCW   = 2'd0,
        OP_CLEX   = 2'd1,
        OP_WAIT   = 2'd2,
        OP_NOWAIT = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        MD_REAL = 2'd0,
        MD_PROT = 2'd1,
        MD_V86  = 2'd2,
        MD_LONG = 2'd3
    } cpu_mode_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_UD   = 3'd1,
        FLT_NM   = 3'd2,
        FLT_AC   = 3'd3,
        FLT_MF   = 3'd4
    } fault_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_ARMED = 1'b1
    } pend_state_e;

    localparam int          CW_W     = 16;
    localparam int          NEXC     = 6;
    localparam logic [1:0]  TOP_CPL  = 2'd3;
    localparam logic [15:0] CW_RESET = 16'h037F;
endpackage

// File: rtl/fpcw_pend_detect.sv
`timescale 1ns/1ps
module fpcw_pend_detect #(
    parameter int NEXC = 6
) (
    input  logic [NEXC-1:0] flags,
    input  logic [NEXC-1:0] masks,
    output logic            pending
);
    logic [NEXC-1:0] hit;

    // A flag counts toward the pending condition only when its mask bit is 0.
    for (genvar i = 0; i < NEXC; i++) begin : g_bit
        assign hit[i] = flags[i] & ~masks[i];
    end

    assign pending = |hit;
endmodule

// File: rtl/fpcw_fault_chk.sv
`timescale 1ns/1ps
module fpcw_fault_chk
    import fpcw_pkg::*;
(
    input  logic      op_valid,
    input  op_class_e op_class,
    input  logic      lock_pfx,
    input  logic      cr0_em,
    input  logic      cr0_ts,
    input  logic      ac_en,
    input  logic [1:0] cpl,
    input  cpu_mode_e cpu_mode,
    input  logic      addr_misalign,
    input  logic      armed,
    output fault_e    code
);
    logic ring_hit;
    logic ac_hit;
    logic mf_hit;

    // Alignment applies at any level in virtual-8086 mode, and only at the
    // top level in protected and 64-bit modes.
    always_comb begin
        unique case (cpu_mode)
            MD_REAL:          ring_hit = 1'b0;
            MD_V86:           ring_hit = 1'b1;
            MD_PROT, MD_LONG: ring_hit = (cpl == TOP_CPL);
            default:          ring_hit = 1'b0;
        endcase
    end

    assign ac_hit = (op_class == OP_LDCW) && addr_misalign && ac_en && ring_hit;

    assign mf_hit = armed &&
                    ((op_class == OP_WAIT) ||
                     ((op_class == OP_LDCW) && (cpu_mode == MD_LONG)));

    // Fixed priority: invalid opcode, device, alignment, math.
    always_comb begin
        code = FLT_NONE;
        if (op_valid) begin
            if (lock_pfx)             code = FLT_UD;
            else if (cr0_em | cr0_ts) code = FLT_NM;
            else if (ac_hit)          code = FLT_AC;
            else if (mf_hit)          code = FLT_MF;
        end
    end
endmodule

// File: rtl/fpcw_unit.sv
`timescale 1ns/1ps
module fpcw_unit
    import fpcw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [1:0]  op_class,
    input  logic [15:0] ld_data,
    input  logic [5:0]  flag_set,
    input  logic        lock_pfx,
    input  logic        cr0_em,
    input  logic        cr0_ts,
    input  logic        ac_en,
    input  logic [1:0]  cpl,
    input  logic [1:0]  cpu_mode,
    input  logic        addr_misalign,
    output logic [15:0] ctrl_word,
    output logic [5:0]  stat_flags,
    output logic        fault_vld,
    output logic [2:0]  fault_code
);
    pend_state_e     state_q, state_d;
    logic [CW_W-1:0] cw_q, cw_d;
    logic [NEXC-1:0] flg_q, flg_d;
    fault_e          code;
    logic            pend_next;
    op_class_e       cls;

    assign cls = op_class_e'(op_class);

    fpcw_fault_chk u_chk (
        .op_valid      (op_valid),
        .op_class      (cls),
        .lock_pfx      (lock_pfx),
        .cr0_em        (cr0_em),
        .cr0_ts        (cr0_ts),
        .ac_en         (ac_en),
        .cpl           (cpl),
        .cpu_mode      (cpu_mode_e'(cpu_mode)),
        .addr_misalign (addr_misalign),
        .armed         (state_q == ST_ARMED),
        .code          (code)
    );

    // Commit logic: nothing changes unless the op passed every check.
    always_comb begin
        cw_d  = cw_q;
        flg_d = flg_q;
        if (op_valid && (code == FLT_NONE)) begin
            unique case (cls)
                OP_LDCW:           cw_d  = ld_data;
                OP_CLEX:           flg_d = '0;
                OP_WAIT, OP_NOWAIT: flg_d = flg_q | flag_set;
                default:           cw_d  = cw_q;
            endcase
        end
    end

    fpcw_pend_detect #(.NEXC(NEXC)) u_pend (
        .flags   (flg_d),
        .masks   (cw_d[NEXC-1:0]),
        .pending (pend_next)
    );

    // Transitions ARM and DISARM; all other cases hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (pend_next)  state_d = ST_ARMED;
            ST_ARMED: if (!pend_next) state_d = ST_QUIET;
            default:  state_d = ST_QUIET;
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            cw_q    <= CW_RESET;
            flg_q   <= '0;
        end else begin
            state_q <= state_d;
            cw_q    <= cw_d;
            flg_q   <= flg_d;
        end
    end

    // Output process: registered fault report.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_vld  <= 1'b0;
            fault_code <= FLT_NONE;
        end else begin
            fault_vld  <= (code != FLT_NONE);
            fault_code <= code;
        end
    end

    assign ctrl_word  = cw_q;
    assign stat_flags = flg_q;

    // Assertion support: set after the first edge out of reset.
    logic chk_live;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_live <= 1'b0;
        else        chk_live <= 1'b1;
    end

    // R10
    fault_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && fault_vld) |-> (ctrl_word == $past(ctrl_word) && stat_flags == $past(stat_flags)));

    // R6
    lock_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(op_valid && lock_pfx)) |-> (fault_vld && fault_code == FLT_UD));

    // R12
    quiet_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_vld |-> (fault_code == FLT_NONE));

    // R4
    nowait_no_mf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(op_valid && op_class == OP_NOWAIT)) |-> (fault_code != FLT_MF));

    // R5
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && !fault_vld && $past(op_valid && op_class == OP_CLEX)) |-> (stat_flags == '0));

    // R3
    mf_needs_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && fault_code == FLT_MF) |-> $past(state_q == ST_ARMED));
endmodule

// File: tb/fpcw_unit_bench.sv
`timescale 1ns/1ps
module fpcw_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic [15:0] ld_data = 16'h0;
    logic [5:0]  flag_set = 6'h0;
    logic        lock_pfx = 1'b0, cr0_em = 1'b0, cr0_ts = 1'b0, ac_en = 1'b0;
    logic [1:0]  cpl = 2'd0, cpu_mode = 2'd1;
    logic        addr_misalign = 1'b0;
    logic [15:0] ctrl_word;
    logic [5:0]  stat_flags;
    logic        fault_vld;
    logic [2:0]  fault_code;

    int errors = 0;
    int checks = 0;
    int m_cw;
    int m_fl;
    int e_code;

    always #2.5 clk = ~clk;

    fpcw_unit u_fpcw_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .ld_data(ld_data), .flag_set(flag_set), .lock_pfx(lock_pfx),
        .cr0_em(cr0_em), .cr0_ts(cr0_ts), .ac_en(ac_en), .cpl(cpl),
        .cpu_mode(cpu_mode), .addr_misalign(addr_misalign),
        .ctrl_word(ctrl_word), .stat_flags(stat_flags),
        .fault_vld(fault_vld), .fault_code(fault_code)
    );

    task automatic check(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "ctrl_word", int'(ctrl_word), m_cw);
        check(tag, "stat_flags", int'(stat_flags), m_fl);
        check(tag, "fault_vld", int'(fault_vld), (e_code != 0) ? 1 : 0);
        check(tag, "fault_code", int'(fault_code), e_code);
    endtask

    // Behavioural reference for one instruction.
    task automatic op(string tag, int cls, int d, int fs, bit lk, bit em, bit ts,
                      bit ac, int pl, int md, bit mis);
        bit pend;
        int f;
        pend = ((m_fl & ~m_cw) & 6'h3F) != 0;
        f = 0;
        if (lk) f = 1;
        else if (em || ts) f = 2;
        else if (cls == 0 && mis && ac && (md == 2 || ((md == 1 || md == 3) && pl == 3))) f = 3;
        else if (pend && (cls == 2 || (cls == 0 && md == 3))) f = 4;
        if (f == 0) begin
            if (cls == 0) m_cw = d & 16'hFFFF;
            else if (cls == 1) m_fl = 0;
            else m_fl = m_fl | (fs & 6'h3F);
        end
        e_code = f;
        op_valid = 1'b1; op_class = cls[1:0]; ld_data = d[15:0]; flag_set = fs[5:0];
        lock_pfx = lk; cr0_em = em; cr0_ts = ts; ac_en = ac; cpl = pl[1:0];
        cpu_mode = md[1:0]; addr_misalign = mis;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; lock_pfx = 1'b0; cr0_em = 1'b0; cr0_ts = 1'b0;
        compare_all(tag);
    endtask

    task automatic idle(string tag);
        e_code = 0;
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_cw = 16'h037F; m_fl = 0; e_code = 0;
        repeat (3) @(negedge clk);
        check("R1", "reset ctrl_word", int'(ctrl_word), 16'h037F);
        check("R1", "reset flags", int'(stat_flags), 0);
        check("R1", "reset fault_vld", int'(fault_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 whole-word load, then restore
        op("R2", 0, 16'h1234, 0, 0, 0, 0, 0, 0, 1, 0);
        op("R2", 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 1, 0);
        op("R2", 0, 16'h037F, 0, 0, 0, 0, 0, 0, 1, 0);
        // R11 masked zero-divide flag merged, no fault
        op("R11", 2, 0, 6'b000100, 0, 0, 0, 0, 0, 1, 0);
        // R3 unmask it: load does not fault
        op("R3", 0, 16'h037B, 0, 0, 0, 0, 0, 0, 1, 0);
        // R4 no-wait ops pass by
        op("R4", 3, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        op("R4", 3, 0, 6'b100000, 0, 0, 0, 0, 0, 1, 0);
        // R3 waiting op faults with code 4, R10 nothing changes
        op("R3", 2, 0, 6'b000001, 0, 0, 0, 0, 0, 1, 0);
        idle("R12");
        // R9 64-bit load while armed
        op("R9", 0, 16'h037F, 0, 0, 0, 0, 0, 0, 3, 0);
        // R8 alignment outranks math in 64-bit mode
        op("R8", 0, 16'h037F, 0, 0, 0, 0, 1, 3, 3, 1);
        // R5 clear then unmask everything
        op("R5", 1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        op("R5", 0, 16'h0340, 0, 0, 0, 0, 0, 0, 1, 0);
        op("R5", 2, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        op("R5", 0, 16'h037F, 0, 0, 0, 0, 0, 0, 3, 0);
        // R6 lock outranks all
        op("R6", 0, 16'h0000, 0, 1, 1, 1, 1, 3, 1, 1);
        op("R6", 3, 0, 6'b000010, 1, 0, 0, 0, 0, 1, 0);
        // R7 device bits
        op("R7", 0, 16'h0000, 0, 0, 1, 0, 0, 0, 1, 0);
        op("R7", 1, 0, 0, 0, 0, 1, 0, 0, 1, 0);
        op("R7", 0, 16'h0000, 0, 0, 0, 1, 1, 3, 1, 1);
        // R8 mode/level matrix
        op("R8", 0, 16'h0300, 0, 0, 0, 0, 1, 3, 1, 1);
        op("R8", 0, 16'h0301, 0, 0, 0, 0, 1, 0, 1, 1);
        op("R8", 0, 16'h0302, 0, 0, 0, 0, 1, 0, 2, 1);
        op("R8", 0, 16'h0303, 0, 0, 0, 0, 1, 3, 0, 1);
        op("R8", 0, 16'h0304, 0, 0, 0, 0, 0, 3, 3, 1);
        op("R8", 2, 0, 0, 0, 0, 0, 1, 3, 1, 1);
        op("R8", 0, 16'h037F, 0, 0, 0, 0, 0, 0, 1, 0);
        idle("R12");

        // Random stream against the model
        for (int i = 0; i < 400; i++) begin
            int c, d, fs, pl, md;
            bit lk, em, ts, ac, mis;
            c  = $urandom_range(3);
            d  = $urandom_range(16'hFFFF);
            fs = (($urandom_range(7) == 0) ? (1 << $urandom_range(5)) : 0);
            lk = ($urandom_range(15) == 0);
            em = ($urandom_range(15) == 0);
            ts = ($urandom_range(15) == 0);
            ac = $urandom_range(1);
            mis = ($urandom_range(3) == 0);
            pl = $urandom_range(3);
            md = $urandom_range(3);
            if ($urandom_range(9) == 0) idle("R12");
            else op("R10", c, d, fs, lk, em, ts, ac, pl, md, mis);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule